// File: doc/BRIEF.md
# Serial Majority-Logic Decoder with Early Clean Exit

This block decodes one 15-bit word of the cyclic (15,7) Euclidean-geometry LDPC code. It decodes one bit position per clock cycle. A start pulse copies the received word into a circular register. On every following cycle, four parity sums are taken from fixed taps of that register. All four sums include the top position. A vote then decides whether to invert the top bit, and the register rotates by one place.

The first three cycles also serve as an error test. If every parity sum stayed at zero through those three cycles, the word is taken as error-free. It is returned in its loaded bit order at once, and the error flag is cleared. If any sum was one during those cycles, the register keeps rotating until all fifteen positions have been visited. It then returns the repaired word with the error flag set. Words without errors, which are the usual case for memory reads, therefore cost three cycles instead of fifteen.

Top module: `mld_early_decoder`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `busy`, `done`, `err` and `dout` are all zero.
- R2: A `start` pulse sampled while `busy` is low captures `din`, and `busy` reads one on the next cycle.
- R3: A `start` pulse sampled while `busy` is high has no effect: the running decode finishes at its own time with its own result, and no extra result appears afterwards.
- R4: Bit i of a word is the coefficient of x^i. The valid words are the multiples of g(x) = 1 + x^4 + x^6 + x^7 + x^8 of degree below 15. The four parity sums are the XOR of bit 14 with the bit triples {0,2,6}, {1,5,13}, {3,11,12} and {7,8,10}. Each cycle, bit 14 is inverted when at least three of the four sums are one, and then every bit moves up one place while bit 14 wraps to bit 0.
- R5: When all four sums are zero in each of the first three cycles after capture, `done` rises 3 cycles after the capturing edge, with `dout` equal to the captured word and `err` low.
- R6: When any sum is one in one of the first three cycles, `done` rises 15 cycles after the capturing edge, with `err` high.
- R7: Any valid word with one bit inverted is returned as the original valid word.
- R8: Any valid word with two bits inverted is returned as the original valid word.
- R9: `done` stays high for exactly one cycle per decode, and `busy` falls on the same edge where `done` rises.
- R10: `dout` and `err` change only on the edge where `done` rises, and hold their values until the next result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture `din` and begin a decode (taken only when idle) |
| din | input | 15 | Received word, bit i is coefficient of x^i |
| busy | output | 1 | A decode is in progress |
| done | output | 1 | One-cycle strobe: `dout` and `err` hold a new result |
| dout | output | 15 | Decoded word, in the captured bit order |
| err | output | 1 | The early test found a nonzero parity sum |

## Verification
A clean word must produce its result 3 clock edges after the edge that captured it, and a word with a nonzero parity sum must produce its result 15 edges after that edge. The bench counts rising edges. Each driven start records the edge count into a scoreboard entry together with the expected word and flag. The monitor samples on falling edges. On each `done` it checks the elapsed edge count against 3 or 15, so a result that comes early or late fails even when its value is right. Starts given while busy push no entry, so any stray result from one of them pops an empty queue and is reported.

// File: rtl/mld_pkg.sv
package mld_pkg;
  // Code length and check structure of the (15,7) geometry code
  parameter int CODE_N      = 15;
  parameter int NUM_CHECKS  = 4;
  parameter int TAPS_PER_CK = 3;
  parameter int EARLY_ITERS = 3;

  // Positions joined with the top bit in each parity sum; every
  // position other than the top one appears in at most one row.
  parameter int CHECK_TAPS [NUM_CHECKS][TAPS_PER_CK] = '{
    '{0, 2, 6},
    '{13, 1, 5},
    '{11, 12, 3},
    '{7, 8, 10}
  };

  typedef enum logic {ST_IDLE, ST_RUN} dec_state_t;
endpackage

// File: rtl/mld_checks.sv
module mld_checks
  import mld_pkg::*;
#(
  parameter int N  = CODE_N,
  parameter int NC = NUM_CHECKS,
  parameter int TW = TAPS_PER_CK
) (
  input  logic [N-1:0]  word,
  output logic [NC-1:0] sums
);
  for (genvar c = 0; c < NC; c++) begin : g_chk
    always_comb begin
      logic acc;
      acc = word[N-1];
      for (int t = 0; t < TW; t++) begin
        acc = acc ^ word[CHECK_TAPS[c][t]];
      end
      sums[c] = acc;
    end
  end
endmodule

// File: rtl/mld_vote.sv
module mld_vote #(
  parameter int NC  = 4,
  parameter int THR = NC / 2 + 1
) (
  input  logic [NC-1:0] sums,
  output logic          flip,
  output logic          any_set
);
  localparam int CW = $clog2(NC + 1);

  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < NC; i++) begin
      ones = ones + CW'(sums[i]);
    end
  end

  assign flip    = (ones >= CW'(THR));
  assign any_set = |sums;
endmodule

// File: rtl/mld_ctrl.sv
module mld_ctrl
  import mld_pkg::*;
#(
  parameter int N     = CODE_N,
  parameter int EARLY = EARLY_ITERS
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic any_set,
  output logic load,
  output logic step,
  output logic fin_clean,
  output logic fin_full,
  output logic busy_o,
  output logic done_o,
  output logic err_o
);
  localparam int CNT_W = $clog2(N + 1);

  dec_state_t       state;
  logic [CNT_W-1:0] iter;
  logic             dirty;
  logic             dirty_now;

  assign load      = (state == ST_IDLE) && start;
  assign step      = (state == ST_RUN);
  assign dirty_now = dirty | any_set;
  assign fin_clean = step && (iter == CNT_W'(EARLY - 1)) && !dirty_now;
  assign fin_full  = step && (iter == CNT_W'(N - 1));
  assign busy_o    = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      iter   <= '0;
      dirty  <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load) begin
        state <= ST_RUN;
        iter  <= '0;
        dirty <= 1'b0;
      end else if (step) begin
        iter <= iter + 1'b1;
        if (iter < CNT_W'(EARLY)) begin
          dirty <= dirty_now;
        end
        if (fin_clean || fin_full) begin
          state  <= ST_IDLE;
          done_o <= 1'b1;
          err_o  <= dirty_now;
        end
      end
    end
  end

  // R5
  clean_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !err_o) |-> (iter == CNT_W'(EARLY)));

  // R6
  full_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_o) |-> (iter == CNT_W'(N)));

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start && !fin_clean && !fin_full) |=> (busy_o && !done_o));
endmodule

// File: rtl/mld_early_decoder.sv
module mld_early_decoder
  import mld_pkg::*;
#(
  parameter int N     = CODE_N,
  parameter int NC    = NUM_CHECKS,
  parameter int EARLY = EARLY_ITERS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [N-1:0] din,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] dout,
  output logic         err
);
  logic [N-1:0]  shreg;
  logic [N-1:0]  shreg_next;
  logic [N-1:0]  unrotated;
  logic [NC-1:0] sums;
  logic          flip;
  logic          any_set;
  logic          load;
  logic          step;
  logic          fin_clean;
  logic          fin_full;

  mld_checks #(.N(N), .NC(NC), .TW(TAPS_PER_CK)) u_checks (
    .word (shreg),
    .sums (sums)
  );

  mld_vote #(.NC(NC), .THR(NC / 2 + 1)) u_vote (
    .sums    (sums),
    .flip    (flip),
    .any_set (any_set)
  );

  mld_ctrl #(.N(N), .EARLY(EARLY)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .any_set   (any_set),
    .load      (load),
    .step      (step),
    .fin_clean (fin_clean),
    .fin_full  (fin_full),
    .busy_o    (busy),
    .done_o    (done),
    .err_o     (err)
  );

  // Correct the top bit, then rotate: bit i moves to i+1, top wraps to 0
  assign shreg_next = {shreg[N-2:0], shreg[N-1] ^ flip};

  // A clean exit happens before the last of the early rotations is stored,
  // so the captured order sits EARLY-1 places behind the register.
  for (genvar i = 0; i < N; i++) begin : g_unrot
    assign unrotated[i] = shreg[(i + EARLY - 1) % N];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      dout  <= '0;
    end else begin
      if (load) begin
        shreg <= din;
      end else if (step) begin
        shreg <= shreg_next;
      end
      if (fin_clean) begin
        dout <= unrotated;
      end else if (fin_full) begin
        dout <= shreg_next;
      end
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $fell(busy));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R10
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(dout) && $stable(err)));

  // R4
  early_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (step && flip) |-> any_set);
endmodule

// File: tb/mld_early_decoder_test.sv
module mld_early_decoder_test;
  localparam int N = 15;
  localparam logic [N-1:0] GPOLY = 15'h01D1;

  typedef struct {
    logic [N-1:0] word;
    logic         flag;
    int           t0;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [N-1:0] din = '0;
  logic         busy;
  logic         done;
  logic [N-1:0] dout;
  logic         err;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  exp_t sb[$];

  mld_early_decoder uut (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .din   (din),
    .busy  (busy),
    .done  (done),
    .dout  (dout),
    .err   (err)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [N-1:0] encode(logic [6:0] msg);
    logic [N-1:0] c;
    c = '0;
    for (int i = 0; i < 7; i++) begin
      if (msg[i]) c = c ^ (GPOLY << i);
    end
    return c;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Driver: push the expected result, then pulse start for one cycle
  task automatic send(logic [N-1:0] rx, logic [N-1:0] good, logic flag);
    exp_t e;
    while (busy) @(negedge clk);
    e.word = good;
    e.flag = flag;
    e.t0   = cyc;
    sb.push_back(e);
    start = 1'b1;
    din   = rx;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Monitor: compare each result against the scoreboard head
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R3", "unexpected result", int'(dout), 0);
      end else begin
        exp_t e;
        int lat;
        e = sb.pop_front();
        lat = cyc - e.t0 - 1;
        if (e.flag) begin
          check(dout == e.word, "R8/R7", "word", int'(dout), int'(e.word));
          check(err == 1'b1, "R6", "err flag", int'(err), 1);
          check(lat == 15, "R6", "latency", lat, 15);
        end else begin
          check(dout == e.word, "R5", "clean word", int'(dout), int'(e.word));
          check(err == 1'b0, "R5", "err flag", int'(err), 0);
          check(lat == 3, "R5", "latency", lat, 3);
        end
        check(busy == 1'b0, "R9", "busy at done", int'(busy), 0);
      end
    end
  end

  // R9: done never lasts two cycles
  logic done_q = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (done && done_q) check(1'b0, "R9", "done width", 2, 1);
      done_q <= done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] cw;
    logic [N-1:0] held;
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !done && !err && dout == '0, "R1", "in reset", int'({busy, done, err}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !err && dout == '0, "R1", "after reset", int'(dout), 0);

    // R2: busy follows an idle start
    start = 1'b1;
    din   = encode(7'h2B);
    sb.push_back('{word: encode(7'h2B), flag: 1'b0, t0: cyc});
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    while (busy) @(negedge clk);

    // R5: every valid word takes the clean exit
    for (int m = 0; m < 128; m++) begin
      send(encode(7'(m)), encode(7'(m)), 1'b0);
    end

    // R7: every single-bit error on several words
    for (int m = 1; m < 128; m += 37) begin
      cw = encode(7'(m));
      for (int p = 0; p < N; p++) begin
        send(cw ^ (15'd1 << p), cw, 1'b1);
      end
    end

    // R8: every double-bit error on two words
    for (int k = 0; k < 2; k++) begin
      cw = encode(k == 0 ? 7'h00 : 7'h5A);
      for (int a = 0; a < N; a++) begin
        for (int b = a + 1; b < N; b++) begin
          send(cw ^ (15'd1 << a) ^ (15'd1 << b), cw, 1'b1);
        end
      end
    end

    // R3: a start given mid-decode is ignored
    cw = encode(7'h11);
    send(cw ^ 15'h0100, cw, 1'b1);
    @(negedge clk);
    check(busy == 1'b1, "R3", "busy before stray start", int'(busy), 1);
    start = 1'b1;
    din   = encode(7'h33);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R3", "still busy", int'(busy), 1);
    while (busy) @(negedge clk);

    // R10: result holds while idle
    held = dout;
    repeat (20) @(negedge clk);
    check(dout == held, "R10", "dout held", int'(dout), int'(held));
    check(err == 1'b1, "R10", "err held", int'(err), 1);
    check(sb.size() == 0, "R3", "pending results", sb.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule